// File: doc/BRIEF.md
# Period-Derived Interleaved Compare Timer

This block is an up-counter that runs from zero to a programmed period. It emits a one-cycle pulse when it reaches the period and one pulse for each of three compare thresholds. In the overriding modes the thresholds that the counter actually uses are worked out in hardware from the period: half of it, thirds of it, or quarters of it. Software then only has to program one number, the period, to get evenly phase-shifted edges for two-, three- or four-phase interleaved power stages. The compare values that software writes stay readable exactly as written. The internal active copies are what change.

A set/reset output turns the compare-1 event and the period event into a square wave of either polarity. A preload option holds the derived values back until an external update pulse arrives. When preload is off, the new values take effect one cycle after the write. In an overriding mode a period that is too short for the selected prescaler setting raises a sticky error flag, and the timer keeps counting. The register port is plain. It has no handshake and no back-pressure, and every write takes effect at the clock edge on which `wr_en` is high.

Top module: `ilv_cmp_timer`

## Requirements
- R1: After reset the period register reads all ones, the three user compares and the control register read 0, the counter is 0, and `wave` and `err_flag` are low.
- R2: The counter steps by one each cycle. `per_evt` is high for the cycle in which the counter is at or above the period, and the counter is 0 on the next cycle.
- R3: `cmp_evt[i]` is high in exactly the cycle where the counter equals active compare i. A value above the period never fires.
- R4: The control register is written at address 4 and holds the bits [0] half, [2:1] interleave, [3] preload, [4] polarity and [7:5] prescale. With half=1 the mode is dual, whatever the interleave code. With half=0, interleave 00 is disabled, 01 is triple, 10 is quad and 11 is reserved.
- R5: In dual mode, active compare 1 is period/2, truncated. Active compares 2 and 3 follow the user compares.
- R6: In triple mode, active compare 1 is period/3 and active compare 2 is 2*period/3, both truncated. Active compare 3 follows the user compare 3.
- R7: In quad mode, the active compares are period/4, period/2 and 3*period/4, all truncated.
- R8: In disabled mode and in reserved mode, the active compares follow the user compares written at addresses 1 to 3.
- R9: Reading addresses 1 to 3 always returns the value last written there, in every mode. The period reads back at address 0 and the control register at address 4.
- R10: With preload=0, the active compares take their new target one cycle after a write. With preload=1, they change only on a cycle where `upd_evt` is high.
- R11: With polarity 0, `wave` goes high one cycle after a compare-1 event and low one cycle after a period event. Polarity 1 swaps these two actions. When both events fall in the same cycle, the period event's action wins.
- R12: `err_flag` is set while dual, triple or quad mode is active and the period is below 192 shifted right by the prescale value. It stays set until a write of 1 in bit 0 to address 5, and a clear that arrives while the condition still holds leaves it set. Disabled and reserved modes never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 period, 1-3 compares, 4 control, 5 error clear |
| wr_data | input | W | Write data |
| upd_evt | input | 1 | Update pulse that loads the active compares when preload is on |
| rd_addr | input | 3 | Read address, same map as the write address |
| rd_data | output | W | Combinational read data |
| cnt | output | W | Current counter value |
| per_evt | output | 1 | Period event pulse |
| cmp_evt | output | 3 | Compare event pulses, bit i for active compare i+1 |
| wave | output | 1 | Set/reset square-wave output |
| err_flag | output | 1 | Sticky minimum-period error |

## Verification
The bench sweeps every period from 24 to 40 in dual, triple and quad modes and measures where each event lands within a full counter cycle. A divider that rounded up, or a threshold taken from the wrong fraction, would move an event by a cycle at some residue of the period. The bench also checks that the written compare still reads back after the override, so a design that wrote the derived value into the user register would fail there. Preload is exercised by shortening the period without an update pulse: a design that applied the new value early would put the compare-1 event at the new half instead of the old one. The error flag is driven at several prescale settings and cleared both with the fault present and with it removed, which catches a wrong threshold shift, a flag that is not sticky, and a clear given priority over a live fault.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  localparam int NCMP     = 3;
  localparam int CTRL_W   = 8;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] A_PER  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP3 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] A_ECLR = 3'd5;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_TRIPLE = 2'd2,
    MODE_QUAD   = 2'd3
  } mode_e;

  typedef struct packed {
    logic [2:0] psc;
    logic       pol;
    logic       preload;
    logic [1:0] ilv;
    logic       half;
  } ctrl_t;

  function automatic mode_e decode_mode(ctrl_t c);
    if (c.half) return MODE_DUAL;
    case (c.ilv)
      2'b01:   return MODE_TRIPLE;
      2'b10:   return MODE_QUAD;
      default: return MODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/ilv_regs.sv
module ilv_regs
  import ilv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [W-1:0]               rd_data,
  output logic [W-1:0]               per_q,
  output logic [NCMP-1:0][W-1:0]     ucmp_q,
  output ctrl_t                      ctrl_q,
  output logic                       err_clr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= '1;
      ucmp_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_PER) per_q <= wr_data;
      if (wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      for (int i = 0; i < NCMP; i++) begin
        if (wr_addr == A_CMP1 + ADDR_W'(i)) ucmp_q[i] <= wr_data;
      end
    end
  end

  assign err_clr = wr_en && (wr_addr == A_ECLR) && wr_data[0];

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_PER) rd_data = per_q;
    else if (rd_addr == A_CTRL) rd_data = W'(ctrl_q);
    else if (rd_addr >= A_CMP1 && rd_addr <= A_CMP3)
      rd_data = ucmp_q[rd_addr - A_CMP1];
  end

endmodule

// File: rtl/ilv_cmp_calc.sv
module ilv_cmp_calc
  import ilv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           per,
  input  logic [NCMP-1:0][W-1:0] ucmp,
  input  mode_e                  mode,
  input  logic                   preload,
  input  logic                   upd_evt,
  output logic [NCMP-1:0][W-1:0] act_q
);

  logic [W-1:0]   d_half, d_third, d_2third, d_quart, d_3quart;
  logic [W:0]     per_x2;
  logic [W+1:0]   per_x3;
  logic [NCMP-1:0][W-1:0] tgt;

  always_comb begin
    per_x2   = {per, 1'b0};
    per_x3   = {2'b00, per} + {1'b0, per, 1'b0};
    d_half   = per >> 1;
    d_quart  = per >> 2;
    d_third  = per / W'(3);
    d_2third = W'(per_x2 / (W+1)'(3));
    d_3quart = W'(per_x3 >> 2);
  end

  always_comb begin
    tgt = ucmp;
    case (mode)
      MODE_DUAL:   tgt[0] = d_half;
      MODE_TRIPLE: begin
        tgt[0] = d_third;
        tgt[1] = d_2third;
      end
      MODE_QUAD: begin
        tgt[0] = d_quart;
        tgt[1] = d_half;
        tgt[2] = d_3quart;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else if (!preload || upd_evt) act_q <= tgt;
  end

endmodule

// File: rtl/ilv_counter.sv
module ilv_counter
  import ilv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           per,
  input  logic [NCMP-1:0][W-1:0] act,
  output logic [W-1:0]           cnt_q,
  output logic                   per_evt,
  output logic [NCMP-1:0]        cmp_evt
);

  assign per_evt = (cnt_q >= per);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (per_evt) cnt_q <= '0;
    else              cnt_q <= cnt_q + W'(1);
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign cmp_evt[g] = (cnt_q == act[g]);
  end

endmodule

// File: rtl/ilv_outstage.sv
module ilv_outstage
  import ilv_pkg::*;
#(
  parameter int W        = 16,
  parameter int MIN_BASE = 192
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pol,
  input  logic [2:0]   psc,
  input  mode_e        mode,
  input  logic [W-1:0] per,
  input  logic         cmp1_evt,
  input  logic         per_evt,
  input  logic         err_clr,
  output logic         wave_q,
  output logic         err_q
);

  logic [W-1:0] min_per;
  logic         err_set;

  assign min_per = W'(MIN_BASE) >> psc;
  assign err_set = (mode != MODE_OFF) && (per < min_per);

  always_ff @(posedge clk) begin
    if (!rst_n)        wave_q <= 1'b0;
    else if (per_evt)  wave_q <= pol;
    else if (cmp1_evt) wave_q <= ~pol;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

endmodule

// File: rtl/ilv_cmp_timer.sv
module ilv_cmp_timer
  import ilv_pkg::*;
#(
  parameter int W        = 16,
  parameter int MIN_BASE = 192
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            upd_evt,
  input  logic [2:0]      rd_addr,
  output logic [W-1:0]    rd_data,
  output logic [W-1:0]    cnt,
  output logic            per_evt,
  output logic [2:0]      cmp_evt,
  output logic            wave,
  output logic            err_flag
);

  logic [W-1:0]           per_w;
  logic [NCMP-1:0][W-1:0] ucmp_w;
  logic [NCMP-1:0][W-1:0] act_w;
  ctrl_t                  ctrl_w;
  logic                   err_clr_w;
  mode_e                  mode_w;

  assign mode_w = decode_mode(ctrl_w);

  ilv_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .per_q(per_w), .ucmp_q(ucmp_w), .ctrl_q(ctrl_w), .err_clr(err_clr_w)
  );

  ilv_cmp_calc #(.W(W)) u_calc (
    .clk(clk), .rst_n(rst_n), .per(per_w), .ucmp(ucmp_w), .mode(mode_w),
    .preload(ctrl_w.preload), .upd_evt(upd_evt), .act_q(act_w)
  );

  ilv_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .per(per_w), .act(act_w),
    .cnt_q(cnt), .per_evt(per_evt), .cmp_evt(cmp_evt)
  );

  ilv_outstage #(.W(W), .MIN_BASE(MIN_BASE)) u_out (
    .clk(clk), .rst_n(rst_n), .pol(ctrl_w.pol), .psc(ctrl_w.psc),
    .mode(mode_w), .per(per_w), .cmp1_evt(cmp_evt[0]), .per_evt(per_evt),
    .err_clr(err_clr_w), .wave_q(wave), .err_q(err_flag)
  );

endmodule

// File: rtl/ilv_cmp_timer_chk.sv
module ilv_cmp_timer_chk #(
  parameter int W        = 16,
  parameter int MIN_BASE = 192
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     cnt,
  input logic             per_evt,
  input logic [2:0]       cmp_evt,
  input logic             wave,
  input logic             err_flag,
  input logic             err_clr,
  input logic             upd_evt,
  input logic [7:0]       ctrl,
  input logic [W-1:0]     per,
  input logic [3*W-1:0]   act
);

  logic         c_half, c_pre, c_pol;
  logic [1:0]   c_ilv;
  logic [2:0]   c_psc;
  logic         over_mode;
  logic [W-1:0] lim;

  assign c_half    = ctrl[0];
  assign c_ilv     = ctrl[2:1];
  assign c_pre     = ctrl[3];
  assign c_pol     = ctrl[4];
  assign c_psc     = ctrl[7:5];
  assign over_mode = c_half || (c_ilv == 2'b01) || (c_ilv == 2'b10);
  assign lim       = W'(MIN_BASE) >> c_psc;

  AST_PER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> cnt == '0); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !per_evt |=> cnt == $past(cnt) + W'(1)); // R2
  AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_pre && !upd_evt) |=> $stable(act)); // R10
  AST_DUAL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (c_half && !c_pre) |=> act[W-1:0] == ($past(per) >> 1)); // R5
  AST_WAVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_pol && cmp_evt[0] && !per_evt) |=> wave); // R11
  AST_WAVE_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_pol && per_evt) |=> !wave); // R11
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (over_mode && per < lim) |=> err_flag); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag); // R12

endmodule

bind ilv_cmp_timer ilv_cmp_timer_chk #(.W(W), .MIN_BASE(MIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .per_evt(per_evt), .cmp_evt(cmp_evt),
  .wave(wave), .err_flag(err_flag), .err_clr(err_clr_w), .upd_evt(upd_evt),
  .ctrl(ctrl_w), .per(per_w), .act(act_w)
);

// File: tb/sim_ilv_cmp_timer.sv
`timescale 1ns/1ps
module sim_ilv_cmp_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic upd_evt = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [W-1:0] rd_data, cnt;
  logic per_evt, wave, err_flag;
  logic [2:0] cmp_evt;

  int total = 0;
  int bad = 0;
  int m_len, m_hi;
  int m_off [3];

  always #2.5 clk = ~clk;

  ilv_cmp_timer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd_evt(upd_evt), .rd_addr(rd_addr),
    .rd_data(rd_data), .cnt(cnt), .per_evt(per_evt), .cmp_evt(cmp_evt),
    .wave(wave), .err_flag(err_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ctl(int half, int ilv, int pre, int pol, int psc);
    return (psc << 5) | (pol << 4) | (pre << 3) | (ilv << 1) | half;
  endfunction

  task automatic rd(input int a, output int v);
    rd_addr = 3'(a); #0.5; v = int'(rd_data);
  endtask

  // one full counter cycle, starting just after a period event
  task automatic measure();
    @(negedge clk);
    while (!per_evt) @(negedge clk);
    m_len = 0; m_hi = 0;
    for (int i = 0; i < 3; i++) m_off[i] = 0;
    for (int k = 1; k < 70000; k++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) if (cmp_evt[i] && m_off[i] == 0) m_off[i] = k;
      if (wave) m_hi++;
      if (per_evt) begin m_len = k; break; end
    end
  endtask

  function automatic int exp_off(int c, int p);
    return (c <= p) ? c + 1 : 0;
  endfunction

  function automatic int exp_hi(int c, int p, int pol);
    if (pol == 0) return (c <= p) ? p - c : 0;
    return (c <= p) ? c + 1 : p + 1;
  endfunction

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    int e [3];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 cnt", int'(cnt), 0);
    chk("R1 wave", int'(wave), 0);
    chk("R1 err", int'(err_flag), 0);
    rd(0, v); chk("R1 period", v, 16'hFFFF);
    for (int a = 1; a <= 4; a++) begin rd(a, v); chk("R1 regs", v, 0); end

    // R5 R6 R7 R2 R3 R11: sweep modes and periods at prescale 3 (limit 24)
    wr(1, 2); wr(2, 3); wr(3, 4);
    for (int m = 0; m < 3; m++) begin
      for (int p = 24; p <= 40; p++) begin
        int pol = p & 1;
        wr(4, ctl(m == 0, (m == 1) ? 1 : (m == 2) ? 2 : 0, 0, pol, 3));
        wr(0, p);
        measure(); measure();
        if (m == 0) begin e[0] = p / 2; e[1] = 3; e[2] = 4; end
        else if (m == 1) begin e[0] = p / 3; e[1] = (2 * p) / 3; e[2] = 4; end
        else begin e[0] = p / 4; e[1] = p / 2; e[2] = (3 * p) / 4; end
        chk("R2 period length", m_len, p + 1);
        chk(m == 0 ? "R5 cmp1" : m == 1 ? "R6 cmp1" : "R7 cmp1", m_off[0], exp_off(e[0], p));
        chk(m == 0 ? "R5 cmp2" : m == 1 ? "R6 cmp2" : "R7 cmp2", m_off[1], exp_off(e[1], p));
        chk("R3 cmp3", m_off[2], exp_off(e[2], p));
        chk("R11 wave high cycles", m_hi, exp_hi(e[0], p, pol));
        chk("R12 no error above limit", int'(err_flag), 0);
      end
    end

    // R9 readback survives override (quad mode)
    wr(1, 7);
    rd(1, v); chk("R9 cmp1 readback", v, 7);
    rd(2, v); chk("R9 cmp2 readback", v, 3);
    rd(0, v); chk("R9 period readback", v, 40);
    measure(); measure();
    chk("R7 cmp1 still derived", m_off[0], 11);

    // R8 R4 disabled and reserved follow user compares, no error below limit
    wr(1, 5); wr(2, 9); wr(3, 13);
    for (int il = 0; il < 4; il += 3) begin
      wr(4, ctl(0, il, 0, 0, 3));
      wr(0, 20);
      measure(); measure();
      chk("R8 cmp1 user", m_off[0], 6);
      chk("R8 cmp2 user", m_off[1], 10);
      chk("R8 cmp3 user", m_off[2], 14);
      chk("R4 R12 no error in off mode", int'(err_flag), 0);
      wr(0, 30);
    end

    // R4 half overrides the interleave code
    wr(4, ctl(1, 2, 0, 0, 3)); wr(0, 30);
    measure(); measure();
    chk("R4 half wins cmp1", m_off[0], 16);
    chk("R4 half wins cmp2", m_off[1], 10);

    // R10 preload
    wr(0, 40); measure();
    wr(4, ctl(1, 0, 1, 0, 3));
    wr(0, 30);
    measure(); measure();
    chk("R10 held before update", m_off[0], 21);
    upd_evt = 1'b1; @(negedge clk); upd_evt = 1'b0;
    measure(); measure();
    chk("R10 loaded on update", m_off[0], 16);

    // R12 limit, stickiness and clear priority
    wr(4, ctl(1, 0, 0, 0, 0));
    wr(0, 100); @(negedge clk);
    chk("R12 set psc0", int'(err_flag), 1);
    wr(0, 200); @(negedge clk);
    chk("R12 sticky", int'(err_flag), 1);
    wr(5, 1);
    chk("R12 cleared", int'(err_flag), 0);
    wr(0, 191); @(negedge clk);
    chk("R12 psc0 191", int'(err_flag), 1);
    wr(4, ctl(0, 1, 0, 0, 2));
    wr(0, 48); wr(5, 1);
    chk("R12 psc2 48 ok", int'(err_flag), 0);
    wr(0, 47); @(negedge clk);
    chk("R12 psc2 47", int'(err_flag), 1);
    wr(5, 1);
    chk("R12 clear loses to live fault", int'(err_flag), 1);
    wr(4, ctl(0, 2, 0, 0, 1));
    wr(0, 96); wr(5, 1);
    chk("R12 psc1 96 ok", int'(err_flag), 0);
    wr(0, 95); @(negedge clk);
    chk("R12 psc1 95", int'(err_flag), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule